// File: doc/BRIEF.md
# Product-Term Logic Block with Output Macrocells

This block is one logic tile of a programmable device. A programmable AND plane forms product terms from literals. Each literal is an external input or a macrocell feedback line, taken in true or complemented form. The product terms feed fixed OR gates. Every macrocell owns a dedicated group of terms, and no term is shared between macrocells. Each OR result goes through a polarity XOR that the configuration controls. From there it reaches a D flip-flop with an enable and an output selector, which presents either the stored bit or the live combinational value.

The flip-flop outputs return to the AND plane, so a function can span two levels or hold state. For example, a stored `g = BC + B'C'` can drive `f = A'g + Ag'` in the next cycle. Only flip-flop values are fed back, so no configuration can form a combinational loop.

Before use, the whole configuration is shifted in one bit per clock. This covers the AND links and, for each macrocell, the invert, select and enable bits. A synchronous reset clears the flip-flops and the configuration together.

Top module: `pal_block`

## Requirements
- R1: While `cfgShift` is high and `rst` is low, each rising clock edge shifts the configuration vector up by one bit and places `cfgData` at index 0. The bit sent first therefore ends at the top index. Product term p, literal l is at index p*LITS+l, where LITS = 2*(NUM_IN+NUM_MC). Above all links, macrocell m has its invert bit at base+3m, its select-combinational bit at base+3m+1 and its enable bit at base+3m+2.
- R2: Literal 2s is source s in true form and literal 2s+1 is its complement. Sources 0..NUM_IN-1 are `extIn` bits, and source NUM_IN+m is the flip-flop of macrocell m. A product term is the AND of its linked literals.
- R3: Macrocell m ORs exactly its own terms m*PT_PER_MC through m*PT_PER_MC+PT_PER_MC-1, the last term of the group included.
- R4: When a macrocell's invert bit is 1, its OR result is complemented before the flip-flop and before the combinational output.
- R5: When the select bit is 1, the macrocell output is the combinational value. When it is 0, the output is the flip-flop value.
- R6: With its enable bit at 1, the flip-flop loads the polarity-corrected OR result on each rising edge. With the enable bit at 0, it keeps its value.
- R7: Feedback comes only from flip-flops and is available in both polarities. This makes two-level functions and counters possible, each updating once per clock.
- R8: A rising edge with `rst` high clears every flip-flop and every configuration bit, so all outputs read 0.
- R9: While `cfgShift` is high, no flip-flop changes.
- R10: A product term with no linked literal evaluates to 0, so an empty group gives 0, or 1 when inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset of flip-flops and configuration |
| cfgShift | input | 1 | Configuration shift strobe |
| cfgData | input | 1 | Serial configuration bit |
| extIn | input | NUM_IN | External inputs to the AND plane |
| mcOut | output | NUM_MC | Macrocell outputs |

## Verification
One configuration places ten distinct macrocell set-ups side by side. These are an equality function, its stored copy, a two-level XOR built on that stored copy, an inverted NAND, a disabled register, a D register, a self-toggling counter, two empty groups with either polarity, and a wide OR that uses the last term of its group. All sixteen input codes are applied in a scrambled order. Across them, the bench separates wrong literal polarity, a wrong term group, a missing invert, a wrong output select, an ignored enable, and feedback that is stale or combinational. Directed sequences then reload the same configuration mid-run to show that the registers hold. A final reset with all inputs high shows that both the flip-flops and the configuration are cleared.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  // control strobes from the sequencing logic into the datapath
  typedef struct packed {
    logic clear;   // synchronous clear of state and configuration
    logic shift;   // configuration shift this cycle
    logic run;     // flip-flops may update this cycle
  } strobe_t;

  // per-macrocell configuration, three bits, invert at the lowest position
  typedef struct packed {
    logic enable;
    logic useComb;
    logic invert;
  } mc_cfg_t;

  localparam int MC_CFG_W = 3;
endpackage

// File: rtl/pal_ctrl.sv
`timescale 1ns/1ps
module pal_ctrl
  import pal_pkg::*;
(
  input  logic    rst,
  input  logic    cfgShift,
  output strobe_t strobe
);
  always_comb begin
    strobe.clear = rst;
    strobe.shift = cfgShift & ~rst;
    strobe.run   = ~cfgShift & ~rst;
  end
endmodule

// File: rtl/pal_cfg_chain.sv
`timescale 1ns/1ps
module pal_cfg_chain
  import pal_pkg::*;
#(
  parameter int CFG_BITS = 64
) (
  input  logic                clk,
  input  strobe_t             strobe,
  input  logic                cfgData,
  output logic [CFG_BITS-1:0] cfgVec
);
  always_ff @(posedge clk) begin
    if (strobe.clear)      cfgVec <= '0;
    else if (strobe.shift) cfgVec <= {cfgVec[CFG_BITS-2:0], cfgData};
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.shift |=> cfgVec[0] == $past(cfgData));

  // R1
  chain_idle_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.shift |=> $stable(cfgVec));
endmodule

// File: rtl/pal_macrocell.sv
`timescale 1ns/1ps
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int PT = 5
) (
  input  logic          clk,
  input  strobe_t       strobe,
  input  logic [PT-1:0] termVec,
  input  mc_cfg_t       cfg,
  output logic          ffQ,
  output logic          mcOut
);
  logic orRes;
  logic dVal;
  logic enEff;

  always_comb begin
    orRes = |termVec;
    dVal  = orRes ^ cfg.invert;
    enEff = strobe.run & cfg.enable;
    mcOut = cfg.useComb ? dVal : ffQ;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) ffQ <= 1'b0;
    else if (enEff)   ffQ <= dVal;
  end

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !enEff |=> $stable(ffQ));

  // R6
  load_when_on_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    enEff |=> ffQ == $past(dVal));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    strobe.clear |=> !ffQ);
endmodule

// File: rtl/pal_logic.sv
`timescale 1ns/1ps
module pal_logic
  import pal_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_MC    = 16,
  parameter int PT_PER_MC = 5
) (
  input  logic           clk,
  input  strobe_t        strobe,
  input  logic [NUM_IN-1:0] extIn,
  input  logic [NUM_MC*PT_PER_MC*2*(NUM_IN+NUM_MC)+MC_CFG_W*NUM_MC-1:0] cfgVec,
  output logic [NUM_MC-1:0] mcOut
);
  localparam int NUM_SRC  = NUM_IN + NUM_MC;
  localparam int NUM_LIT  = 2 * NUM_SRC;
  localparam int NUM_PT   = NUM_MC * PT_PER_MC;
  localparam int AND_BITS = NUM_PT * NUM_LIT;

  logic [NUM_MC-1:0]  ffVec;
  logic [NUM_SRC-1:0] srcVec;
  logic [NUM_LIT-1:0] litVec;
  logic [NUM_PT-1:0]  termVec;

  // feedback is taken from flip-flops only, never from the output selector
  assign srcVec = {ffVec, extIn};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lit
    assign litVec[2*s]   = srcVec[s];
    assign litVec[2*s+1] = ~srcVec[s];
  end

  for (genvar p = 0; p < NUM_PT; p++) begin : g_term
    logic [NUM_LIT-1:0] linkMask;
    assign linkMask   = cfgVec[p*NUM_LIT +: NUM_LIT];
    // an unlinked term is forced low instead of floating to 1
    assign termVec[p] = (|linkMask) & (&(litVec | ~linkMask));
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    mc_cfg_t cfgM;
    assign cfgM = cfgVec[AND_BITS + MC_CFG_W*m +: MC_CFG_W];
    pal_macrocell #(.PT(PT_PER_MC)) u_mc (
      .clk    (clk),
      .strobe (strobe),
      .termVec(termVec[m*PT_PER_MC +: PT_PER_MC]),
      .cfg    (cfgM),
      .ffQ    (ffVec[m]),
      .mcOut  (mcOut[m])
    );
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.shift |=> $stable(ffVec));
endmodule

// File: rtl/pal_block.sv
`timescale 1ns/1ps
module pal_block
  import pal_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_MC    = 16,
  parameter int PT_PER_MC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgShift,
  input  logic              cfgData,
  input  logic [NUM_IN-1:0] extIn,
  output logic [NUM_MC-1:0] mcOut
);
  localparam int NUM_LIT  = 2 * (NUM_IN + NUM_MC);
  localparam int CFG_BITS = NUM_MC * PT_PER_MC * NUM_LIT + MC_CFG_W * NUM_MC;

  strobe_t             strobe;
  logic [CFG_BITS-1:0] cfgVec;

  pal_ctrl u_ctrl (
    .rst     (rst),
    .cfgShift(cfgShift),
    .strobe  (strobe)
  );

  pal_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
    .clk    (clk),
    .strobe (strobe),
    .cfgData(cfgData),
    .cfgVec (cfgVec)
  );

  pal_logic #(.NUM_IN(NUM_IN), .NUM_MC(NUM_MC), .PT_PER_MC(PT_PER_MC)) u_logic (
    .clk   (clk),
    .strobe(strobe),
    .extIn (extIn),
    .cfgVec(cfgVec),
    .mcOut (mcOut)
  );
endmodule

// File: tb/pal_block_tb.sv
`timescale 1ns/1ps
module pal_block_tb;
  localparam int NUM_IN   = 4;
  localparam int NUM_MC   = 16;
  localparam int PT       = 5;
  localparam int LITS     = 2 * (NUM_IN + NUM_MC);
  localparam int AND_BITS = NUM_MC * PT * LITS;
  localparam int CFG_BITS = AND_BITS + 3 * NUM_MC;
  localparam logic [3:0] STIM [16] = '{4'h0, 4'hF, 4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h5,
                                       4'h6, 4'h9, 4'hA, 4'hC, 4'h7, 4'hB, 4'hD, 4'hE};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgShift = 1'b0;
  logic cfgData = 1'b0;
  logic [NUM_IN-1:0] extIn = '0;
  logic [NUM_MC-1:0] mcOut;

  int nChecks = 0;
  int nFail = 0;
  logic [CFG_BITS-1:0] cfgImg;
  logic mG, mD, mT;
  logic [NUM_MC-1:0] expV;

  always #10 clk = ~clk;

  pal_block u_dut (
    .clk(clk), .rst(rst), .cfgShift(cfgShift), .cfgData(cfgData),
    .extIn(extIn), .mcOut(mcOut)
  );

  task automatic chk(input string tag, input logic [NUM_MC-1:0] mask);
    nChecks++;
    if ((mcOut & mask) !== (expV & mask)) begin
      nFail++;
      $display("FAIL %s: mcOut=%h expected=%h (mask %h)", tag, mcOut & mask, expV & mask, mask);
    end
  endtask

  task automatic link(input int mc, input int k, input int src, input bit neg);
    cfgImg[(mc*PT + k)*LITS + 2*src + int'(neg)] = 1'b1;
  endtask

  task automatic mcSet(input int mc, input bit inv, input bit comb, input bit en);
    cfgImg[AND_BITS + 3*mc]     = inv;
    cfgImg[AND_BITS + 3*mc + 1] = comb;
    cfgImg[AND_BITS + 3*mc + 2] = en;
  endtask

  task automatic loadCfg();
    for (int i = CFG_BITS - 1; i >= 0; i--) begin
      @(negedge clk);
      cfgShift = 1'b1;
      cfgData  = cfgImg[i];
    end
    @(negedge clk);
    cfgShift = 1'b0;
  endtask

  function automatic logic [NUM_MC-1:0] model(input logic [3:0] v);
    logic a, b, c, d;
    logic [NUM_MC-1:0] e;
    {d, c, b, a} = v;
    e = '0;
    e[0] = (b & c) | (~b & ~c);
    e[1] = mG;
    e[2] = a ^ mG;
    e[3] = ~(a & b);
    e[5] = mD;
    e[6] = mT;
    e[8] = 1'b1;
    e[9] = a | b | c | d;
    return e;
  endfunction

  initial begin
    #(200000 * 20);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expV = '0;
    chk("R8 reset state", '1);
    rst = 1'b0;
    @(negedge clk);
    #5 chk("R8 cleared config idles at zero", '1);

    cfgImg = '0;
    link(0, 0, 1, 0); link(0, 0, 2, 0); link(0, 1, 1, 1); link(0, 1, 2, 1); mcSet(0, 0, 1, 1);
    link(1, 0, 1, 0); link(1, 0, 2, 0); link(1, 1, 1, 1); link(1, 1, 2, 1); mcSet(1, 0, 0, 1);
    link(2, 0, 0, 1); link(2, 0, 5, 0); link(2, 1, 0, 0); link(2, 1, 5, 1); mcSet(2, 0, 1, 0);
    link(3, 0, 0, 0); link(3, 0, 1, 0); mcSet(3, 1, 1, 0);
    link(4, 0, 0, 0); mcSet(4, 0, 0, 0);
    link(5, 0, 3, 0); mcSet(5, 0, 0, 1);
    link(6, 0, 10, 1); mcSet(6, 0, 0, 1);
    mcSet(7, 0, 1, 0);
    mcSet(8, 1, 1, 0);
    link(9, 0, 0, 0); link(9, 1, 1, 0); link(9, 2, 2, 0); link(9, 4, 3, 0); mcSet(9, 0, 1, 0);
    extIn = 4'h0;
    loadCfg();
    mG = 0; mD = 0; mT = 0;

    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      extIn = STIM[i];
      #5;
      expV = model(STIM[i]);
      if (i == 0) chk("R9 registers held during load", 16'h0062);
      chk("R1 R2 equality from literal polarity", 16'h0001);
      chk("R3 wide OR incl last term", 16'h0200);
      chk("R4 inverted product", 16'h0008);
      chk("R10 empty groups", 16'h0180);
      chk("R5 registered select", 16'h0002);
      chk("R7 two-level xor via feedback", 16'h0004);
      chk("R6 disabled reg stays, enabled reg loads", 16'h0030);
      chk("R7 toggle counter", 16'h0040);
      mG = (STIM[i][1] & STIM[i][2]) | (~STIM[i][1] & ~STIM[i][2]);
      mD = STIM[i][3];
      mT = ~mT;
    end

    // reload the same configuration mid-run: state must hold (R9)
    loadCfg();
    #5;
    expV = model(extIn);
    chk("R9 state kept across reload", '1);

    @(negedge clk);
    rst = 1'b1;
    extIn = 4'hF;
    @(negedge clk);
    expV = '0;
    chk("R8 reset clears flip-flops and outputs", '1);
    rst = 1'b0;
    @(negedge clk);
    #5 chk("R8 configuration cleared by reset", '1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule